// File: doc/BRIEF.md
# Byte-Bus 16-Bit Timer with Event Capture

This block is a 16-bit timer/counter that an 8-bit processor bus reaches one byte at a time. A single high-byte holding register, shared by the counter and the capture register, makes every 16-bit read and write behave as one indivisible step. To read, software fetches the low byte first, which also freezes the matching high byte in the holding register. To write, software places the high byte in the holding register first, and the low-byte write then loads all 16 bits in a single cycle.

A clock-select field picks one of several external tick strobes, and the value zero halts counting. A mode bit selects plain up-counting with wrap-around, or a triangle sequence that counts up and then down. The direction of the triangle sequence is a two-state machine. In `DIR_UP`, a tick at the maximum value takes the transition *turn-down* to `DIR_DOWN`. In `DIR_DOWN`, a tick at zero takes the transition *turn-up* back to `DIR_UP`. Clearing the mode bit forces `DIR_UP` (*force-up*).

An event-capture path takes either an external pin or a comparator output. It synchronises the chosen input through two flip-flops, detects the chosen edge, and stores the counter value as a time-stamp. An overflow flag and a capture flag are cleared by writing ones to them.

Top module: `tmr16_byte_bus`

## Requirements
- R1: After reset the counter, the capture register, the holding register, the control byte and both flags are zero, so the counter is stopped.
- R2: A read of address 0 returns counter bits 7:0 and, at the same clock edge, copies counter bits 15:8 into the holding register. A read of address 1 returns the holding register, even if the counter has moved since.
- R3: A write to address 1 or address 3 stores the byte in the holding register. A write to address 0 loads the counter with {holding register, written byte} in one cycle.
- R4: Control byte (address 4) bits 2:0 select the tick source. Value 0 stops the counter, and the counter can still be read and written. Value k advances the counter only on cycles where tick strobe k-1 is high.
- R5: A write to address 0 in the same cycle as an enabled tick loads the written value, and the tick is lost.
- R6: With control bit 3 clear, each tick adds one. A tick at 0xFFFF wraps to 0 and sets the overflow flag (flag byte bit 0, address 5).
- R7: With control bit 3 set, the counter counts up to 0xFFFF, then down to 0, then up again. The overflow flag is set when a down-count reaches 0 and not at the turn at 0xFFFF.
- R8: Output at_top is high exactly when the counter is 0xFFFF, and at_bottom exactly when it is 0.
- R9: A detected capture event copies the counter into the capture register and sets the capture flag (flag byte bit 1). The event is detected at the third clock edge after the input changes. A read of address 2 returns capture bits 7:0 and copies capture bits 15:8 into the holding register.
- R10: Control bit 4 set selects rising edges, and clear selects falling edges. The other edge leaves the capture register and the capture flag unchanged.
- R11: Control bit 5 clear takes events from the pin, and set takes them from the comparator. Edges on the source that is not selected are ignored.
- R12: Writing a byte to address 5 clears each flag whose bit is 1 and leaves each flag whose bit is 0 unchanged. If a flag is set and cleared in the same cycle, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_taps | input | 7 | Tick strobes, one per nonzero clock-select value |
| cap_pin | input | 1 | External capture pin (asynchronous) |
| cmp_out | input | 1 | Comparator output usable as capture source (asynchronous) |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| at_top | output | 1 | Counter equals 0xFFFF |
| at_bottom | output | 1 | Counter equals 0 |
| ovf_flag | output | 1 | Overflow flag |
| cap_flag | output | 1 | Capture flag |

## Verification
On every cycle, the assertions check the following: a write beats a tick, the counter holds when no tick is enabled, the up-only step, the *turn-down* transition, the capture latch and its hold, the holding-register copy on a low-byte read, and the set-wins and clear rules of the overflow flag. Only the bench scenarios can show effects that span several bus accesses or observe the ports from outside. These are: a high byte that stays consistent across a tick between the two reads, a complete triangle sequence with overflow only at the bottom, the three-edge capture latency, edge and source selection, and the behaviour when the clock select is zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd5;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_t;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             updown,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             at_top,
    output logic             at_bottom,
    output logic             ovf_evt
);
    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    dir_t             dir_q, dir_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_UP;
            cnt_q <= '0;
        end else begin
            dir_q <= dir_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        dir_d   = dir_q;
        cnt_d   = cnt_q;
        ovf_evt = 1'b0;
        if (!updown) dir_d = DIR_UP;
        if (load_en) begin
            cnt_d = load_val;
        end else if (tick) begin
            if (!updown) begin
                cnt_d = cnt_q + ONE;
                if (cnt_q == TOP) ovf_evt = 1'b1;
            end else begin
                unique case (dir_q)
                    DIR_UP: begin
                        if (cnt_q == TOP) begin
                            cnt_d = cnt_q - ONE;
                            dir_d = DIR_DOWN;
                        end else begin
                            cnt_d = cnt_q + ONE;
                        end
                    end
                    DIR_DOWN: begin
                        if (cnt_q == '0) begin
                            cnt_d = cnt_q + ONE;
                            dir_d = DIR_UP;
                        end else begin
                            cnt_d = cnt_q - ONE;
                            if (cnt_q == ONE) ovf_evt = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        cnt       = cnt_q;
        at_top    = (cnt_q == TOP);
        at_bottom = (cnt_q == '0);
    end

    p_write_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> cnt_q == $past(load_val));
    p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en) |=> cnt_q == $past(cnt_q));
    p_up_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en && !updown) |=> cnt_q == CNT_W'($past(cnt_q) + ONE));
    p_turn_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en && updown && dir_q == DIR_UP && cnt_q == TOP) |=> dir_q == DIR_DOWN);
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_pin,
    input  logic             src_cmp,
    input  logic             use_cmp,
    input  logic             rising,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_evt
);
    logic             sync1_q, sync2_q, prev_q;
    logic [CNT_W-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
            cap_q   <= '0;
        end else begin
            sync1_q <= use_cmp ? src_cmp : src_pin;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
            if (cap_evt) cap_q <= cnt;
        end
    end

    always_comb begin
        cap_evt = rising ? (sync2_q & ~prev_q) : (~sync2_q & prev_q);
        cap_val = cap_q;
    end

    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_q == $past(cnt));
    p_cap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |=> $stable(cap_q));
endmodule

// File: rtl/tmr16_byte_bus.sv
module tmr16_byte_bus
    import tmr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [(1<<SEL_W)-2:0]  tick_taps,
    input  logic                   cap_pin,
    input  logic                   cmp_out,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_rd,
    input  logic                   bus_wr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   at_top,
    output logic                   at_bottom,
    output logic                   ovf_flag,
    output logic                   cap_flag
);
    localparam int CNT_W  = 2 * DATA_W;
    localparam int NSRC   = (1 << SEL_W) - 1;
    localparam int B_MODE = SEL_W;
    localparam int B_EDGE = SEL_W + 1;
    localparam int B_SRC  = SEL_W + 2;

    logic [SEL_W-1:0]  sel_q;
    logic              updown_q, rising_q, usecmp_q;
    logic [DATA_W-1:0] temp_q;
    logic              ovf_q, capf_q;
    logic              tick, load_en, ovf_evt, cap_evt;
    logic [CNT_W-1:0]  cnt, cap_val;

    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NSRC; i++)
            if (int'(sel_q) == i + 1) tick = tick_taps[i];
    end

    assign load_en = bus_wr && (bus_addr == A_CNT_LO);

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .updown(updown_q),
        .load_en(load_en), .load_val({temp_q, bus_wdata}),
        .cnt(cnt), .at_top(at_top), .at_bottom(at_bottom), .ovf_evt(ovf_evt)
    );

    tmr_capture #(.CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .src_pin(cap_pin), .src_cmp(cmp_out),
        .use_cmp(usecmp_q), .rising(rising_q), .cnt(cnt),
        .cap_val(cap_val), .cap_evt(cap_evt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '0;
            updown_q <= 1'b0;
            rising_q <= 1'b0;
            usecmp_q <= 1'b0;
            temp_q   <= '0;
            ovf_q    <= 1'b0;
            capf_q   <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == A_CTRL) begin
                sel_q    <= bus_wdata[SEL_W-1:0];
                updown_q <= bus_wdata[B_MODE];
                rising_q <= bus_wdata[B_EDGE];
                usecmp_q <= bus_wdata[B_SRC];
            end
            if (bus_wr && (bus_addr == A_CNT_HI || bus_addr == A_CAP_HI))
                temp_q <= bus_wdata;
            else if (bus_rd && bus_addr == A_CNT_LO)
                temp_q <= cnt[CNT_W-1:DATA_W];
            else if (bus_rd && bus_addr == A_CAP_LO)
                temp_q <= cap_val[CNT_W-1:DATA_W];
            if (ovf_evt) ovf_q <= 1'b1;
            else if (bus_wr && bus_addr == A_FLAGS && bus_wdata[0]) ovf_q <= 1'b0;
            if (cap_evt) capf_q <= 1'b1;
            else if (bus_wr && bus_addr == A_FLAGS && bus_wdata[1]) capf_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CNT_LO: bus_rdata = cnt[DATA_W-1:0];
            A_CNT_HI: bus_rdata = temp_q;
            A_CAP_LO: bus_rdata = cap_val[DATA_W-1:0];
            A_CAP_HI: bus_rdata = temp_q;
            A_CTRL: begin
                bus_rdata[SEL_W-1:0] = sel_q;
                bus_rdata[B_MODE]    = updown_q;
                bus_rdata[B_EDGE]    = rising_q;
                bus_rdata[B_SRC]     = usecmp_q;
            end
            A_FLAGS: begin
                bus_rdata[0] = ovf_q;
                bus_rdata[1] = capf_q;
            end
            default: bus_rdata = '0;
        endcase
        ovf_flag = ovf_q;
        cap_flag = capf_q;
    end

    p_temp_on_low_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == A_CNT_LO) |=> temp_q == $past(cnt[CNT_W-1:DATA_W]));
    p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_q);
    p_ovf_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_FLAGS && bus_wdata[0] && !ovf_evt) |=> !ovf_q);
    p_capf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> capf_q);
endmodule

// File: tb/tb_tmr16_byte_bus.sv
module tb_tmr16_byte_bus;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] tick_taps = '0;
    logic       cap_pin = 1'b0, cmp_out = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       at_top, at_bottom, ovf_flag, cap_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr16_byte_bus dut (
        .clk(clk), .rst_n(rst_n), .tick_taps(tick_taps), .cap_pin(cap_pin),
        .cmp_out(cmp_out), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .at_top(at_top),
        .at_bottom(at_bottom), .ovf_flag(ovf_flag), .cap_flag(cap_flag)
    );

    task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic load16(logic [15:0] v);
        wr(3'd1, v[15:8]);
        wr(3'd0, v[7:0]);
    endtask

    task automatic read_cnt(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(3'd0, lo);
        rd(3'd1, hi);
        v = {hi, lo};
    endtask

    task automatic tick(int idx);
        @(negedge clk);
        tick_taps[idx] = 1'b1;
        @(negedge clk);
        tick_taps[idx] = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        logic [7:0]  b;
        read_cnt(v);          chk("R1", "counter", v, 16'h0000);
        rd(3'd4, b);          chk("R1", "control", {8'h0, b}, 16'h0000);
        rd(3'd5, b);          chk("R1", "flags", {8'h0, b}, 16'h0000);
        rd(3'd2, b);          chk("R1", "capture lo", {8'h0, b}, 16'h0000);
        chk("R8", "at_bottom at 0", {15'h0, at_bottom}, 16'h1);
        chk("R8", "at_top at 0", {15'h0, at_top}, 16'h0);
    endtask

    task automatic t_atomic;
        logic [15:0] v;
        logic [7:0]  lo, hi;
        load16(16'h1234);
        read_cnt(v);          chk("R3", "16-bit load", v, 16'h1234);
        wr(3'd4, 8'h01);
        load16(16'h12FF);
        rd(3'd0, lo);
        tick(0);
        rd(3'd1, hi);         chk("R2", "high byte frozen", {hi, lo}, 16'h12FF);
        read_cnt(v);          chk("R2", "after tick", v, 16'h1300);
    endtask

    task automatic t_stop;
        logic [15:0] v;
        wr(3'd4, 8'h00);
        load16(16'h0100);
        for (int i = 0; i < 7; i++) tick(i);
        read_cnt(v);          chk("R4", "sel 0 stops", v, 16'h0100);
        wr(3'd4, 8'h02);
        tick(0);
        read_cnt(v);          chk("R4", "wrong tap ignored", v, 16'h0100);
        tick(1);
        read_cnt(v);          chk("R4", "selected tap counts", v, 16'h0101);
    endtask

    task automatic t_write_wins;
        logic [15:0] v;
        wr(3'd4, 8'h01);
        wr(3'd1, 8'hAB);
        @(negedge clk);
        tick_taps[0] = 1'b1;
        bus_addr = 3'd0; bus_wdata = 8'hCD; bus_wr = 1'b1;
        @(negedge clk);
        tick_taps[0] = 1'b0; bus_wr = 1'b0;
        read_cnt(v);          chk("R5", "write beats tick", v, 16'hABCD);
    endtask

    task automatic t_up_wrap;
        logic [15:0] v;
        logic [7:0]  b;
        wr(3'd4, 8'h01);
        load16(16'hFFFE);
        tick(0);
        chk("R8", "at_top at FFFF", {15'h0, at_top}, 16'h1);
        chk("R6", "no ovf before wrap", {15'h0, ovf_flag}, 16'h0);
        tick(0);
        read_cnt(v);          chk("R6", "wrap to 0", v, 16'h0000);
        rd(3'd5, b);          chk("R6", "ovf flag bit 0", {8'h0, b}, 16'h0001);
    endtask

    task automatic t_flag_clear;
        wr(3'd5, 8'h00);
        chk("R12", "write 0 keeps flag", {15'h0, ovf_flag}, 16'h1);
        wr(3'd5, 8'h01);
        chk("R12", "write 1 clears flag", {15'h0, ovf_flag}, 16'h0);
    endtask

    task automatic t_updown;
        logic [15:0] v;
        wr(3'd4, 8'h09);
        load16(16'hFFFE);
        tick(0); tick(0);
        read_cnt(v);          chk("R7", "turned at top", v, 16'hFFFE);
        chk("R7", "no ovf at top", {15'h0, ovf_flag}, 16'h0);
        tick(0);
        read_cnt(v);          chk("R7", "keeps counting down", v, 16'hFFFD);
        load16(16'h0002);
        tick(0);
        chk("R7", "no ovf at 1", {15'h0, ovf_flag}, 16'h0);
        tick(0);
        chk("R7", "ovf at bottom", {15'h0, ovf_flag}, 16'h1);
        chk("R8", "at_bottom", {15'h0, at_bottom}, 16'h1);
        tick(0);
        read_cnt(v);          chk("R7", "turned at bottom", v, 16'h0001);
        wr(3'd5, 8'h01);
    endtask

    task automatic t_capture_edge;
        logic [7:0] lo, hi;
        wr(3'd4, 8'h10);
        load16(16'h4321);
        @(negedge clk); cap_pin = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9", "not yet captured", {15'h0, cap_flag}, 16'h0);
        @(negedge clk);
        chk("R9", "capture flag", {15'h0, cap_flag}, 16'h1);
        rd(3'd2, lo); rd(3'd3, hi);
        chk("R9", "capture value", {hi, lo}, 16'h4321);
        wr(3'd5, 8'h02);
        load16(16'h1111);
        @(negedge clk); cap_pin = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10", "falling ignored flag", {15'h0, cap_flag}, 16'h0);
        rd(3'd2, lo); rd(3'd3, hi);
        chk("R10", "falling ignored value", {hi, lo}, 16'h4321);
        wr(3'd4, 8'h00);
        @(negedge clk); cap_pin = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10", "rising ignored in falling mode", {15'h0, cap_flag}, 16'h0);
        load16(16'h5555);
        @(negedge clk); cap_pin = 1'b0;
        repeat (4) @(negedge clk);
        rd(3'd2, lo); rd(3'd3, hi);
        chk("R10", "falling captured", {hi, lo}, 16'h5555);
        wr(3'd5, 8'h02);
    endtask

    task automatic t_capture_src;
        logic [7:0] lo, hi;
        wr(3'd4, 8'h30);
        load16(16'h0A0B);
        @(negedge clk); cap_pin = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11", "pin ignored", {15'h0, cap_flag}, 16'h0);
        @(negedge clk); cmp_out = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11", "comparator flag", {15'h0, cap_flag}, 16'h1);
        rd(3'd2, lo); rd(3'd3, hi);
        chk("R11", "comparator value", {hi, lo}, 16'h0A0B);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_atomic();
        t_stop();
        t_write_wins();
        t_up_wrap();
        t_flag_clear();
        t_updown();
        t_capture_edge();
        t_capture_src();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule